// File: doc/BRIEF.md
# Queue Doorbell Write Handler

This block sits behind the register slave of a storage controller and turns 32-bit register writes into queue pointer updates. Each queue pair owns two 4-byte slots in a doorbell window that starts at a parameterised base. A write to the even slot moves the submission queue tail. A write to the odd slot moves the completion queue head. Each write is checked against the number of queues and against the queue size. A bad write posts a one-cycle error event with a code, and no pointer changes.

After a good completion head write, the block requests an interrupt on the queue's vector if entries are still outstanding. It also pulses a pending-clear strobe for that vector once every completion queue mapped to the vector has drained. A one-shot countdown of about 5 µs produces a single-cycle submission-processing trigger. A submission tail write starts the countdown only when it is not already running. A head write to a completion queue that was full restarts it. Queue sizes, completion tails, vector mapping and interrupt enables come in as inputs.

Top module: `qdbHandler`

## Requirements
- R1: A write hits the window when `wrAddr >= DB_BASE` (default 0x1000). Slot = (wrAddr − DB_BASE) >> 2, so address bits [1:0] are ignored. Queue id = slot >> 1. Slot bit 0 = 0 selects the submission tail and 1 selects the completion head. Writes below the base change nothing and post no event.
- R2: Only wrData[15:0] is used as the new pointer; wrData[31:16] has no effect.
- R3: A queue id ≥ NUM_Q gives errValid for one cycle with errCode = 1 and changes no pointer.
- R4: A pointer ≥ the size of the addressed queue gives errValid for one cycle with errCode = 2 and changes no pointer. errCode is 0 whenever errValid is low.
- R5: A good write is visible on sqTail or cqHead after the next clock edge. Every output is zero after reset.
- R6: After a good head write whose cqTail differs from the new head, irqReq pulses for one cycle and irqVector carries cqVector of that queue.
- R7: After a good head write to a queue with cqIrqEn set, pendClr pulses for one cycle with pendVector = that queue's vector, provided every queue mapped to that vector has head equal to cqTail (the new head counts for the written queue).
- R8: A good tail write starts the countdown only if it is idle. procTrigger rises DELAY_CYC clock edges after the starting write's edge. DELAY_CYC = ceil(CLK_MHZ × DELAY_NS / 1000), 625 by default.
- R9: A good head write to a completion queue that was full before the write restarts the countdown at DELAY_CYC, even if it is already running. Full means (cqTail + 1) mod size equals the old head.
- R10: procTrigger lasts one cycle and leaves the countdown idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| wrEn | input | 1 | register write strobe |
| wrAddr | input | ADDR_W | byte address of the write |
| wrData | input | 32 | write data |
| sqSize | input | NUM_Q×16 | submission queue sizes |
| cqSize | input | NUM_Q×16 | completion queue sizes |
| cqTail | input | NUM_Q×16 | completion queue tails |
| cqVector | input | NUM_Q×VEC_W | vector of each completion queue |
| cqIrqEn | input | NUM_Q | interrupt enable per completion queue |
| sqTail | output | NUM_Q×16 | submission tail pointers |
| cqHead | output | NUM_Q×16 | completion head pointers |
| irqReq | output | 1 | interrupt request pulse |
| irqVector | output | VEC_W | vector for irqReq |
| pendClr | output | 1 | pending-clear pulse |
| pendVector | output | VEC_W | vector for pendClr |
| errValid | output | 1 | error event pulse |
| errCode | output | 2 | 1 bad queue id, 2 bad pointer |
| procTrigger | output | 1 | submission-processing trigger pulse |

## Verification
The assertions check the local rules on every cycle:
- pointers hold without an update strobe;
- error events follow a write;
- pending clears follow a head update;
- the trigger is a one-cycle pulse from an armed countdown;
- an error and an interrupt never appear together.

Only the bench's scenarios can show the values themselves. It compares them against its own model: which slot decodes to which queue, the exact trigger cycle, whether a running countdown is left alone or restarted, and the drain test across queues that share a vector.

// File: rtl/qdbPkg.sv
package qdbPkg;
  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_BAD_QID = 2'd1,
    ERR_BAD_PTR = 2'd2
  } errCodeT;

  typedef struct packed {
    logic        sqWr;
    logic        cqWr;
    logic        cqWasFull;
    logic [7:0]  qid;
    logic [15:0] ptr;
  } dbStrobeT;
endpackage

// File: rtl/qdbCtrl.sv
module qdbCtrl
  import qdbPkg::*;
#(
  parameter int NUM_Q   = 4,
  parameter int ADDR_W  = 16,
  parameter int DB_BASE = 'h1000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [31:0]            wrData,
  input  logic [NUM_Q-1:0][15:0] sqSize,
  input  logic [NUM_Q-1:0][15:0] cqSize,
  input  logic [NUM_Q-1:0][15:0] cqTail,
  input  logic [NUM_Q-1:0][15:0] cqHeadCur,
  output dbStrobeT               strb,
  output logic                   errValid,
  output errCodeT                errCode
);
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

  logic [ADDR_W-1:0] offs;
  logic [ADDR_W-4:0] qidWide;
  logic [QW-1:0]     qid;
  logic              hit, isCq, qidBad, ptrBad, wasFull;
  logic [15:0]       ptr, limit, nxtTail;
  logic [16:0]       tailInc;

  always_comb begin
    offs    = wrAddr - ADDR_W'(DB_BASE);
    hit     = wrEn && (wrAddr >= ADDR_W'(DB_BASE));
    isCq    = offs[2];
    qidWide = offs[ADDR_W-1:3];
    qid     = qidWide[QW-1:0];
    qidBad  = qidWide >= (ADDR_W-3)'(NUM_Q);
    ptr     = wrData[15:0];
    limit   = isCq ? cqSize[qid] : sqSize[qid];
    ptrBad  = ptr >= limit;
    tailInc = {1'b0, cqTail[qid]} + 17'd1;
    nxtTail = (tailInc == {1'b0, cqSize[qid]}) ? 16'd0 : tailInc[15:0];
    wasFull = (nxtTail == cqHeadCur[qid]);

    strb           = '0;
    strb.qid       = 8'(qid);
    strb.ptr       = ptr;
    strb.sqWr      = hit && !qidBad && !ptrBad && !isCq;
    strb.cqWr      = hit && !qidBad && !ptrBad && isCq;
    strb.cqWasFull = wasFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errValid <= 1'b0;
      errCode  <= ERR_NONE;
    end else begin
      errValid <= hit && (qidBad || ptrBad);
      errCode  <= !hit ? ERR_NONE : qidBad ? ERR_BAD_QID : ptrBad ? ERR_BAD_PTR : ERR_NONE;
    end
  end

  p_err_needs_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> $past(wrEn));
  p_err_code_pair_r4: assert property (@(posedge clk) disable iff (!rstN)
    !errValid |-> errCode == ERR_NONE);
endmodule

// File: rtl/qdbDatapath.sv
module qdbDatapath
  import qdbPkg::*;
#(
  parameter int NUM_Q     = 4,
  parameter int VEC_W     = 2,
  parameter int DELAY_CYC = 625
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dbStrobeT                  strb,
  input  logic [NUM_Q-1:0][15:0]    cqTail,
  input  logic [NUM_Q-1:0][VEC_W-1:0] cqVector,
  input  logic [NUM_Q-1:0]          cqIrqEn,
  output logic [NUM_Q-1:0][15:0]    sqTailQ,
  output logic [NUM_Q-1:0][15:0]    cqHeadQ,
  output logic                      irqReq,
  output logic [VEC_W-1:0]          irqVector,
  output logic                      pendClr,
  output logic [VEC_W-1:0]          pendVector,
  output logic                      procTrigger
);
  localparam int QW  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
  localparam int CNW = $clog2(DELAY_CYC + 1);

  logic [QW-1:0]    q;
  logic [VEC_W-1:0] vec;
  logic             drained, armed, startSq, restartCq;
  logic [CNW-1:0]   cnt;

  always_comb begin
    q       = strb.qid[QW-1:0];
    vec     = cqVector[q];
    drained = 1'b1;
    for (int i = 0; i < NUM_Q; i++) begin
      if (cqVector[i] == vec) begin
        if (((i == int'(q)) ? strb.ptr : cqHeadQ[i]) != cqTail[i]) drained = 1'b0;
      end
    end
    restartCq = strb.cqWr && strb.cqWasFull;
    startSq   = strb.sqWr && !armed;
  end

  for (genvar g = 0; g < NUM_Q; g++) begin : gPtr
    always_ff @(posedge clk) begin
      if (!rstN) begin
        sqTailQ[g] <= '0;
        cqHeadQ[g] <= '0;
      end else begin
        if (strb.sqWr && q == QW'(g)) sqTailQ[g] <= strb.ptr;
        if (strb.cqWr && q == QW'(g)) cqHeadQ[g] <= strb.ptr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqReq     <= 1'b0;
      irqVector  <= '0;
      pendClr    <= 1'b0;
      pendVector <= '0;
    end else begin
      irqReq     <= strb.cqWr && (cqTail[q] != strb.ptr);
      irqVector  <= strb.cqWr ? vec : '0;
      pendClr    <= strb.cqWr && cqIrqEn[q] && drained;
      pendVector <= (strb.cqWr && cqIrqEn[q] && drained) ? vec : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed       <= 1'b0;
      cnt         <= '0;
      procTrigger <= 1'b0;
    end else if (restartCq || startSq) begin
      armed       <= 1'b1;
      cnt         <= CNW'(DELAY_CYC);
      procTrigger <= 1'b0;
    end else if (armed && cnt == CNW'(1)) begin
      armed       <= 1'b0;
      cnt         <= '0;
      procTrigger <= 1'b1;
    end else begin
      cnt         <= armed ? cnt - CNW'(1) : cnt;
      procTrigger <= 1'b0;
    end
  end

  p_sq_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.sqWr |=> $stable(sqTailQ));
  p_cq_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cqWr |=> $stable(cqHeadQ));
  p_pend_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    pendClr |-> $past(strb.cqWr));
  p_trig_from_armed_r8: assert property (@(posedge clk) disable iff (!rstN)
    procTrigger |-> $past(armed));
  p_trig_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    procTrigger |=> !procTrigger);
endmodule

// File: rtl/qdbHandler.sv
module qdbHandler
  import qdbPkg::*;
#(
  parameter int NUM_Q    = 4,
  parameter int NUM_VEC  = 4,
  parameter int VEC_W    = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  parameter int ADDR_W   = 16,
  parameter int DB_BASE  = 'h1000,
  parameter int CLK_MHZ  = 125,
  parameter int DELAY_NS = 5000
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [31:0]                 wrData,
  input  logic [NUM_Q-1:0][15:0]      sqSize,
  input  logic [NUM_Q-1:0][15:0]      cqSize,
  input  logic [NUM_Q-1:0][15:0]      cqTail,
  input  logic [NUM_Q-1:0][VEC_W-1:0] cqVector,
  input  logic [NUM_Q-1:0]            cqIrqEn,
  output logic [NUM_Q-1:0][15:0]      sqTail,
  output logic [NUM_Q-1:0][15:0]      cqHead,
  output logic                        irqReq,
  output logic [VEC_W-1:0]            irqVector,
  output logic                        pendClr,
  output logic [VEC_W-1:0]            pendVector,
  output logic                        errValid,
  output logic [1:0]                  errCode,
  output logic                        procTrigger
);
  localparam int DELAY_CYC = (CLK_MHZ * DELAY_NS + 999) / 1000;

  dbStrobeT strb;
  errCodeT  errCodeE;

  qdbCtrl #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W), .DB_BASE(DB_BASE)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sqSize(sqSize), .cqSize(cqSize), .cqTail(cqTail), .cqHeadCur(cqHead),
    .strb(strb), .errValid(errValid), .errCode(errCodeE)
  );

  qdbDatapath #(.NUM_Q(NUM_Q), .VEC_W(VEC_W), .DELAY_CYC(DELAY_CYC)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cqTail(cqTail), .cqVector(cqVector),
    .cqIrqEn(cqIrqEn), .sqTailQ(sqTail), .cqHeadQ(cqHead), .irqReq(irqReq),
    .irqVector(irqVector), .pendClr(pendClr), .pendVector(pendVector),
    .procTrigger(procTrigger)
  );

  assign errCode = errCodeE;

  p_err_excludes_irq_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(irqReq && errValid));
endmodule

// File: tb/tb_qdbHandler.sv
module tb_qdbHandler;
  localparam int NQ = 4, VW = 2, AW = 16, BASE = 'h1000, DLY = 625;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [NQ-1:0][15:0] sqSize, cqSize, cqTail;
  logic [NQ-1:0][VW-1:0] cqVector;
  logic [NQ-1:0] cqIrqEn;
  logic [NQ-1:0][15:0] sqTail, cqHead;
  logic irqReq, pendClr, errValid, procTrigger;
  logic [VW-1:0] irqVector, pendVector;
  logic [1:0] errCode;

  int total = 0, bad = 0;
  logic [15:0] mSq [NQ], mCq [NQ];
  logic mArmed; int mCnt;
  logic eIrq, ePend, eErr, eTrig;
  logic [VW-1:0] eIv, ePv; logic [1:0] eCode;

  always #4 clk = ~clk;

  qdbHandler dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sqSize(sqSize), .cqSize(cqSize), .cqTail(cqTail), .cqVector(cqVector), .cqIrqEn(cqIrqEn),
    .sqTail(sqTail), .cqHead(cqHead), .irqReq(irqReq), .irqVector(irqVector),
    .pendClr(pendClr), .pendVector(pendVector), .errValid(errValid), .errCode(errCode),
    .procTrigger(procTrigger));

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic cqFull(int q);
    int n = (int'(cqTail[q]) + 1) % int'(cqSize[q]);
    return n == int'(mCq[q]);
  endfunction

  function automatic logic vecDrained(int q, logic [15:0] nh);
    for (int i = 0; i < NQ; i++)
      if (cqVector[i] == cqVector[q] && ((i == q) ? nh : mCq[i]) != cqTail[i]) return 1'b0;
    return 1'b1;
  endfunction

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic step(logic en, logic [AW-1:0] a, logic [31:0] d);
    int slot, q; logic cq, good, restart, start; logic [15:0] p;
    wrEn = en; wrAddr = a; wrData = d;
    eIrq = 0; ePend = 0; eErr = 0; eCode = 0; eIv = 0; ePv = 0;
    good = 0; restart = 0; start = 0;
    if (en && a >= AW'(BASE)) begin
      slot = (int'(a) - BASE) >> 2; q = slot >> 1; cq = slot[0]; p = d[15:0];
      if (q >= NQ) begin eErr = 1; eCode = 1; end
      else if (p >= (cq ? cqSize[q] : sqSize[q])) begin eErr = 1; eCode = 2; end
      else good = 1;
      if (good && !cq) begin start = !mArmed; mSq[q] = p; end
      if (good && cq) begin
        restart = cqFull(q);
        eIrq = (cqTail[q] != p); eIv = cqVector[q];
        ePend = cqIrqEn[q] && vecDrained(q, p); ePv = ePend ? cqVector[q] : '0;
        mCq[q] = p;
      end
    end
    if (restart || start) begin mArmed = 1; mCnt = DLY; eTrig = 0; end
    else if (mArmed && mCnt == 1) begin mArmed = 0; mCnt = 0; eTrig = 1; end
    else begin if (mArmed) mCnt--; eTrig = 0; end
    @(posedge clk); @(negedge clk);
    wrEn = 0;
    for (int i = 0; i < NQ; i++) begin
      chk("R1/R2/R3 sqTail", int'(sqTail[i]), int'(mSq[i]));
      chk("R1/R2/R4 cqHead", int'(cqHead[i]), int'(mCq[i]));
    end
    chk("R3/R4 errValid", int'(errValid), int'(eErr));
    chk("R3/R4 errCode", int'(errCode), int'(eCode));
    chk("R6 irqReq", int'(irqReq), int'(eIrq));
    if (eIrq) chk("R6 irqVector", int'(irqVector), int'(eIv));
    chk("R7 pendClr", int'(pendClr), int'(ePend));
    if (ePend) chk("R7 pendVector", int'(pendVector), int'(ePv));
    chk("R8/R9/R10 procTrigger", int'(procTrigger), int'(eTrig));
  endtask

  function automatic logic [AW-1:0] sqA(int q); return AW'(BASE + q * 8); endfunction
  function automatic logic [AW-1:0] cqA(int q); return AW'(BASE + q * 8 + 4); endfunction

  initial begin
    #1600000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed, trigs;
    seed = $urandom(1234);
    sqSize = {16'd32, 16'd4, 16'd16, 16'd8};
    cqSize = {16'd32, 16'd4, 16'd16, 16'd8};
    cqVector = {2'd2, 2'd1, 2'd0, 2'd0};
    cqIrqEn = 4'b0111;
    cqTail = '0;
    for (int i = 0; i < NQ; i++) begin mSq[i] = 0; mCq[i] = 0; end
    mArmed = 0; mCnt = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R5 reset state
    chk("R5 reset sqTail", int'(sqTail), 0);
    chk("R5 reset cqHead", int'(cqHead), 0);
    chk("R5 reset pulses", int'({irqReq, pendClr, errValid, procTrigger}), 0);

    step(1, AW'(BASE - 4), 32'd3);            // R1 below base ignored
    step(1, sqA(1) + 2, 32'hABCD_0005);       // R1 low addr bits, R2 upper data ignored, R8 start
    step(1, sqA(5), 32'd1);                   // R3 bad qid
    step(1, cqA(0), 32'd8);                   // R4 ptr == size
    step(1, sqA(2), 32'd2);                   // R8 armed: no restart
    cqTail[0] = 16'd5; cqTail[1] = 16'd3;
    step(1, cqA(1), 32'd3);                   // R7 q1 drained but q0 on same vector not
    step(1, cqA(0), 32'd6);                   // R6/R7: q0 now full, vector 0 drained? no (tail5)
    step(1, cqA(0), 32'd5);                   // R9 restart from full, R7 drained
    trigs = 0;
    for (int k = 0; k < DLY + 5; k++) begin step(0, '0, '0); trigs += int'(procTrigger); end
    chk("R10 single trigger", trigs, 1);
    step(1, cqA(3), 32'd4);                   // R6 no pend: irq disabled queue

    for (int k = 0; k < 1500; k++) begin
      int slot; logic [31:0] d;
      for (int i = 0; i < NQ; i++) if ($urandom_range(0, 3) == 0)
        cqTail[i] = 16'($urandom_range(0, int'(cqSize[i]) - 1));
      slot = $urandom_range(0, 11);
      d = $urandom();
      d[15:0] = 16'($urandom_range(0, 36));
      if ($urandom_range(0, 9) == 0) step(1, AW'($urandom_range(0, BASE - 1)), d);
      else if ($urandom_range(0, 3) == 0) step(0, '0, '0);
      else step(1, AW'(BASE + slot * 4 + $urandom_range(0, 3)), d);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule